// File: doc/BRIEF.md
# Lockstep Bundle Issue Unit

This block sits between instruction fetch and a row of functional units in a wide-word processor. Each incoming bundle is one long word cut into fixed slots. Every slot position is hard-wired to its own functional unit, so the block does no steering, realignment or dependency analysis. When a bundle is accepted, the block sends one issue strobe to each unit whose slot holds real work. A slot whose field is all zero is a no-operation and issues nothing.

The units have different latencies, and each one reports completion with a done pulse. The block remembers which slots are still in flight. It refuses the next bundle until every issued operation of the current one has reported done, so the slowest unit sets the pace of the whole bundle. When the last completion arrives, the block pulses a retire flag and reopens its input in the same cycle. A saturating counter records every cycle in which a bundle was offered and turned away.

Top module: `vliw_issue_unit`

## Requirements
- R1: During and after reset, with no bundle offered, bundle_ready_o is 1, fu_issue_o is 0, retire_o is 0 and stall_cnt_o is 0.
- R2: A bundle is taken on a clock edge where bundle_valid_i and bundle_ready_o are both 1. bundle_ready_o is 1 exactly when no bundle is in progress.
- R3: In the cycle after a bundle is taken, fu_issue_o[s] is 1 for one cycle for every slot s whose field is non-zero. Slot s occupies bits s*32+31 down to s*32, with slot 0 at the LSB. In that cycle fu_op_o equals the bundle that was taken.
- R4: A slot whose 32-bit field is all zero is a NOP. Its fu_issue_o bit stays 0.
- R5: After a bundle is taken, bundle_ready_o stays 0 until every issued slot has raised fu_done_i. It returns to 1 in the cycle after the last of those done pulses. With per-slot latency L (done pulse L cycles after the issue cycle), ready returns maxL+1 cycles after the issue cycle.
- R6: retire_o pulses for exactly one cycle per bundle, in the cycle where bundle_ready_o returns to 1.
- R7: A bundle in which all four slots are NOPs is still taken and retired. bundle_ready_o is low for exactly one cycle, and retire_o pulses in the second cycle after acceptance.
- R8: fu_done_i is ignored on slots that are not in flight: while idle, and during a bundle on slots that were not issued.
- R9: stall_cnt_o adds one for each cycle with bundle_valid_i = 1 and bundle_ready_o = 0. It holds at its maximum value instead of wrapping.
- R10: While a bundle is in progress, changes on bundle_i issue nothing and leave fu_op_o unchanged. An offer that is held through the stall is taken in the cycle ready returns, and it issues in the following cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bundle_i | input | 128 | Instruction bundle, four 32-bit slots |
| bundle_valid_i | input | 1 | Bundle offered |
| bundle_ready_o | output | 1 | Unit can take a bundle |
| fu_done_i | input | 4 | Per-unit completion pulse |
| fu_issue_o | output | 4 | Per-unit issue strobe |
| fu_op_o | output | 128 | Operation fields of the accepted bundle |
| retire_o | output | 1 | One-cycle pulse when a bundle completes |
| stall_cnt_o | output | 16 | Saturating count of stalled offer cycles |

## Verification
The unit models are latency counters set to 1, 3, 8 and 5 cycles. Single-slot bundles on the fastest and the slowest unit show whether the hold time follows the chosen unit's latency. Mixed bundles show whether the hold time follows the longest issued latency rather than the first done or the slot count, and an all-NOP bundle exercises the zero-work path. Stray done pulses, and a changing bundle word during a stall, show whether state that should be frozen reacts. A held offer across two slow bundles drives the stall count into saturation on a narrowed counter.

// File: rtl/vliw_issue_pkg.sv
package vliw_issue_pkg;
  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_BUSY = 1'b1
  } issue_state_e;
endpackage

// File: rtl/vliw_slot_decode.sv
module vliw_slot_decode #(
  parameter int NUM_SLOTS = 4,
  parameter int SLOT_W    = 32
) (
  input  logic [NUM_SLOTS*SLOT_W-1:0] bundle_i,
  output logic [NUM_SLOTS-1:0]        live_o
);
  for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
    // all-zero field is a NOP
    assign live_o[s] = |bundle_i[s*SLOT_W +: SLOT_W];
  end
endmodule

// File: rtl/vliw_slot_tracker.sv
module vliw_slot_tracker #(
  parameter int NUM_SLOTS = 4
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 load_i,
  input  logic [NUM_SLOTS-1:0] live_i,
  input  logic [NUM_SLOTS-1:0] done_i,
  output logic [NUM_SLOTS-1:0] pending_o,
  output logic                 clear_o
);
  logic [NUM_SLOTS-1:0] pending_q;

  for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)         pending_q[s] <= 1'b0;
      else if (load_i)     pending_q[s] <= live_i[s];
      else if (done_i[s])  pending_q[s] <= 1'b0;
    end

    AST_PENDING_DROPS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (pending_q[s] && done_i[s] && !load_i) |=> !pending_q[s]); // R5
    AST_STRAY_DONE_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!pending_q[s] && !load_i) |=> !pending_q[s]); // R8
  end

  assign pending_o = pending_q;
  // finished once nothing remains that this cycle's done does not cover
  assign clear_o   = ~|(pending_q & ~done_i);
endmodule

// File: rtl/vliw_stall_counter.sv
module vliw_stall_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             stall_i,
  output logic [CNT_W-1:0] count_o
);
  localparam logic [CNT_W-1:0] CntMax = '1;

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                         cnt_q <= '0;
    else if (stall_i && cnt_q != CntMax) cnt_q <= cnt_q + 1'b1;
  end

  assign count_o = cnt_q;

  AST_STALL_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stall_i && cnt_q != CntMax) |=> (cnt_q == $past(cnt_q) + 1'b1)); // R9
  AST_STALL_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!stall_i || cnt_q == CntMax) |=> $stable(cnt_q)); // R9
endmodule

// File: rtl/vliw_issue_unit.sv
module vliw_issue_unit
  import vliw_issue_pkg::*;
#(
  parameter int NUM_SLOTS = 4,
  parameter int SLOT_W    = 32,
  parameter int CNT_W     = 16,
  localparam int BUNDLE_W = NUM_SLOTS * SLOT_W
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [BUNDLE_W-1:0]  bundle_i,
  input  logic                 bundle_valid_i,
  output logic                 bundle_ready_o,
  input  logic [NUM_SLOTS-1:0] fu_done_i,
  output logic [NUM_SLOTS-1:0] fu_issue_o,
  output logic [BUNDLE_W-1:0]  fu_op_o,
  output logic                 retire_o,
  output logic [CNT_W-1:0]     stall_cnt_o
);
  issue_state_e         state_q, state_d;
  logic [NUM_SLOTS-1:0] live, pending, issue_q;
  logic [BUNDLE_W-1:0]  op_q;
  logic                 accept, all_clear, retire_q;

  assign bundle_ready_o = (state_q == ST_IDLE);
  assign accept         = bundle_valid_i && bundle_ready_o;

  vliw_slot_decode #(.NUM_SLOTS(NUM_SLOTS), .SLOT_W(SLOT_W)) u_decode (
    .bundle_i (bundle_i),
    .live_o   (live)
  );

  vliw_slot_tracker #(.NUM_SLOTS(NUM_SLOTS)) u_tracker (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .load_i    (accept),
    .live_i    (live),
    .done_i    (fu_done_i),
    .pending_o (pending),
    .clear_o   (all_clear)
  );

  vliw_stall_counter #(.CNT_W(CNT_W)) u_stall (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .stall_i (bundle_valid_i && !bundle_ready_o),
    .count_o (stall_cnt_o)
  );

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: if (accept)    state_d = ST_BUSY;
      ST_BUSY: if (all_clear) state_d = ST_IDLE;
      default:                state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      issue_q  <= '0;
      op_q     <= '0;
      retire_q <= 1'b0;
    end else begin
      state_q  <= state_d;
      issue_q  <= accept ? live : '0;
      retire_q <= (state_q == ST_BUSY) && all_clear;
      if (accept) op_q <= bundle_i;
    end
  end

  assign fu_issue_o = issue_q;
  assign fu_op_o    = op_q;
  assign retire_o   = retire_q;

  AST_ISSUE_AFTER_ACCEPT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|fu_issue_o) |-> $past(bundle_valid_i && bundle_ready_o)); // R3
  AST_LOCKSTEP_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|pending) |-> !bundle_ready_o); // R5
  AST_RETIRE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    retire_o |=> !retire_o); // R6
  AST_RETIRE_READY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    retire_o |-> bundle_ready_o); // R6
  AST_OP_FROZEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !bundle_ready_o |=> $stable(fu_op_o)); // R10

  for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_nop_chk
    AST_NOP_SILENT: assert property (@(posedge clk_i) disable iff (!rst_ni)
      fu_issue_o[s] |-> (fu_op_o[s*SLOT_W +: SLOT_W] != '0)); // R4
  end
endmodule

// File: tb/vliw_issue_unit_test.sv
module vliw_issue_unit_test;
  localparam int NS = 4;
  localparam int SW = 32;
  localparam int CW = 4;
  localparam logic [CW-1:0] CMAX = '1;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [127:0]  bundle = '0;
  logic          valid = 1'b0;
  logic          ready;
  logic [NS-1:0] fu_done, model_done, extra_done = '0, issue;
  logic [127:0]  op;
  logic          retire;
  logic [CW-1:0] stall_cnt;

  int total = 0;
  int bad = 0;
  int exp_stall = 0;
  int lat [NS] = '{1, 3, 8, 5};
  logic [3:0] cnt [NS];

  always #4ns clk = ~clk;

  vliw_issue_unit #(.NUM_SLOTS(NS), .SLOT_W(SW), .CNT_W(CW)) uut (
    .clk_i          (clk),
    .rst_ni         (rst_n),
    .bundle_i       (bundle),
    .bundle_valid_i (valid),
    .bundle_ready_o (ready),
    .fu_done_i      (fu_done),
    .fu_issue_o     (issue),
    .fu_op_o        (op),
    .retire_o       (retire),
    .stall_cnt_o    (stall_cnt)
  );

  // functional units: done pulse L cycles after the issue cycle
  always_ff @(posedge clk or negedge rst_n) begin
    for (int s = 0; s < NS; s++) begin
      if (!rst_n)          cnt[s] <= '0;
      else if (issue[s])   cnt[s] <= 4'(lat[s]);
      else if (cnt[s] != 0) cnt[s] <= cnt[s] - 1'b1;
    end
  end
  always_comb for (int s = 0; s < NS; s++) model_done[s] = (cnt[s] == 4'd1);
  assign fu_done = model_done | extra_done;

  // expected stall count, from R9
  always @(posedge clk)
    if (rst_n && valid && !ready && exp_stall < int'(CMAX)) exp_stall++;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [127:0] act, input logic [127:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [NS-1:0] mask_of(input logic [127:0] b);
    logic [NS-1:0] m;
    for (int s = 0; s < NS; s++) m[s] = |b[s*SW +: SW];
    return m;
  endfunction

  function automatic int maxlat(input logic [127:0] b);
    int m = 0;
    for (int s = 0; s < NS; s++) if (|b[s*SW +: SW] && lat[s] > m) m = lat[s];
    return m;
  endfunction

  // offer b, check issue, hold time, retire; optional stray dones and held next offer
  task automatic run_bundle(input logic [127:0] b, input logic [NS-1:0] stray,
                            input bit hold, input logic [127:0] nxt);
    int n = 0;
    int ml = maxlat(b);
    @(negedge clk);
    check(ready == 1'b1, "R2", "ready before offer", 128'(ready), 128'd1);
    valid = 1'b1; bundle = b;
    @(negedge clk); // issue cycle
    check(issue == mask_of(b), "R3", "issue mask", 128'(issue), 128'(mask_of(b)));
    check(op == b, "R3", "op fields", op, b);
    check(ready == 1'b0, "R5", "ready drops", 128'(ready), 128'd0);
    if (hold) bundle = nxt; else begin valid = 1'b0; bundle = ~b; end
    extra_done = stray;
    while (!ready && n < 20) begin
      @(negedge clk);
      extra_done = '0;
      n++;
      if (!ready) begin
        check(issue == '0, "R10", "no issue while busy", 128'(issue), 128'd0);
        check(retire == 1'b0, "R6", "no early retire", 128'(retire), 128'd0);
        check(op == b, "R10", "op frozen", op, b);
      end
    end
    check(n == ml + 1, "R5", "hold cycles", 128'(n), 128'(ml + 1));
    check(retire == 1'b1, "R6", "retire with ready", 128'(retire), 128'd1);
    check(int'(stall_cnt) == exp_stall, "R9", "stall count", 128'(stall_cnt), 128'(exp_stall));
    @(negedge clk);
    check(retire == 1'b0, "R6", "retire one cycle", 128'(retire), 128'd0);
    if (hold) begin
      check(issue == mask_of(nxt), "R10", "held offer issues", 128'(issue), 128'(mask_of(nxt)));
      valid = 1'b0;
      n = 0;
      while (!ready && n < 20) begin @(negedge clk); n++; end
      check(n == maxlat(nxt) + 1, "R5", "held bundle hold", 128'(n), 128'(maxlat(nxt) + 1));
      @(negedge clk);
    end
  endtask

  task automatic t_reset;
    @(negedge clk);
    check(ready == 1'b1, "R1", "reset ready", 128'(ready), 128'd1);
    check(issue == '0, "R1", "reset issue", 128'(issue), 128'd0);
    check(retire == 1'b0, "R1", "reset retire", 128'(retire), 128'd0);
    check(stall_cnt == '0, "R1", "reset stall", 128'(stall_cnt), 128'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check(ready == 1'b1 && issue == '0, "R1", "post reset idle", 128'({ready, issue}), 128'h10);
  endtask

  task automatic t_single_fast; // R3 R5 minimum latency
    run_bundle({96'd0, 32'h1111_0001}, '0, 1'b0, '0);
  endtask

  task automatic t_single_slow; // R5 slowest unit alone
    run_bundle({32'd0, 32'hA5A5_0002, 64'd0}, '0, 1'b0, '0);
  endtask

  task automatic t_mixed; // R4 NOP gaps, R5 max latency not slot count
    run_bundle({32'h0000_0300, 64'd0, 32'h8000_0000}, '0, 1'b0, '0);
    run_bundle({64'd0, 32'h0000_0011, 32'h0000_0022}, '0, 1'b0, '0);
  endtask

  task automatic t_all_slots; // R3 R5
    run_bundle({32'h4, 32'h3, 32'h2, 32'h1}, '0, 1'b0, '0);
  endtask

  task automatic t_all_nop; // R7
    run_bundle(128'd0, '0, 1'b0, '0);
  endtask

  task automatic t_stray_done; // R8
    @(negedge clk);
    extra_done = 4'hF;
    @(negedge clk);
    extra_done = '0;
    check(ready == 1'b1 && retire == 1'b0 && issue == '0, "R8", "idle done ignored",
          128'({ready, retire, issue}), 128'h20);
    run_bundle({32'd0, 32'h0000_0009, 64'd0}, 4'b1011, 1'b0, '0);
  endtask

  task automatic t_stall_sat; // R9 R10
    run_bundle({32'd0, 32'h0000_0055, 64'd0}, '0, 1'b1, {32'd0, 32'h0000_0066, 64'd0});
    run_bundle({32'd0, 32'h0000_0077, 64'd0}, '0, 1'b1, {32'h1, 32'h0000_0088, 64'd0});
    check(stall_cnt == CMAX, "R9", "saturated", 128'(stall_cnt), 128'(CMAX));
  endtask

  initial begin
    #(8ns * 200000);
    bad++; total++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk);
    t_reset();
    t_single_fast();
    t_single_slow();
    t_mixed();
    t_all_slots();
    t_all_nop();
    t_stray_done();
    t_stall_sat();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule